// File: doc/BRIEF.md
# Memory-Write Packet Splitter

This block turns one memory-write job from a DMA engine into a train of PCIe memory-write transaction packets. A job gives a start address, a byte count and a stream of data dwords. The block cuts the job into packets, writes a header for each one, and then forwards that packet's share of the data dwords on a single valid/ready output stream.

Each packet is limited by a payload ceiling that is set by a 3-bit code. A packet also never runs past an aligned boundary of that ceiling, so it cannot cross a 4 KB page. The header has three dwords when the packet address is below 4 GB and four dwords otherwise. Packets go out in ascending address order. The block takes a new job only while it is idle, and it pulses `done` once the last data dword has left.

Top module: `wr_tlp_segmenter`

## Requirements
- R1: The payload ceiling in dwords is 32 << code for codes 0..5 (128 to 4096 bytes). Codes 6 and 7 give 32 dwords. The code and the digest flag are captured when a job is accepted, so later changes on those inputs do not affect a job in progress.
- R2: Each packet carries min(remaining dwords, ceiling − (address/4 mod ceiling)) data dwords. No packet crosses a ceiling-aligned boundary or a 4 KB boundary. Data dwords pass through in input order.
- R3: Header dword 0 bits [9:0] hold the payload length in dwords, and 1024 dwords is encoded as 0.
- R4: Header dword 0 bits [31:29] are 3'b010 with a 3-dword header when address bits [63:32] are zero, and 3'b011 with a 4-dword header otherwise. Bits [28:24] are zero.
- R5: Packets are issued in strictly ascending address order, and each one starts where the previous one ended. In a 3-dword header, dword 2 is {addr[31:2],2'b00}. In a 4-dword header, dword 2 is addr[63:32] and dword 3 is {addr[31:2],2'b00}.
- R6: Header dword 0 bit 15 (the digest-present bit) equals the captured `td_en`. The other bits of dword 0 outside Fmt, Type and Length are zero.
- R7: Header dword 1 is {16'h0, 8'h0, last_be, 4'hF}. last_be is 4'h0 when the payload is one dword and 4'hF otherwise.
- R8: `job_ready` is high only when the block is idle, and a job offered while busy is ignored. `done` is high for the one cycle after the final data dword is accepted. `out_sop` marks header dword 0 and `out_eop` marks the last data dword of each packet. Reset leaves `job_ready`=1, `out_valid`=0 and `done`=0.
- R9: A header beat that is stalled by `out_ready`=0 stays valid and unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Block idle, job taken on this cycle if valid |
| job_addr | input | 64 | Start byte address (bits 1:0 ignored) |
| job_bytes | input | BC_W | Byte count, a nonzero multiple of 4 |
| mps_code | input | 3 | Encoded payload ceiling |
| td_en | input | 1 | Digest will follow each packet |
| in_data | input | 32 | Source data dword |
| in_valid | input | 1 | Source data valid |
| in_ready | output | 1 | Source data taken |
| out_data | output | 32 | Header or payload dword |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_sop | output | 1 | First header dword of a packet |
| out_eop | output | 1 | Last payload dword of a packet |
| done | output | 1 | Job finished (one-cycle pulse) |

## Verification
The hardest case to reach is a job whose packets change header format partway through. This happens when a packet ends exactly at the 4 GB line and the next packet needs a 4-dword header. The same job must also hit the 1024-dword length that encodes as zero. The sweep reaches both by starting jobs just below 4 GB and at aligned addresses with the largest ceiling. The runs use every code, including the two reserved ones. Output stalls and input gaps follow coprime patterns, so headers are stalled in every position. In one job per address, the bench keeps a conflicting job and a different code on the inputs while the first job is still running.

// File: rtl/wr_tlp_segmenter.sv
module wr_tlp_segmenter #(
  parameter int BC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            job_valid,
  output logic            job_ready,
  input  logic [63:0]     job_addr,
  input  logic [BC_W-1:0] job_bytes,
  input  logic [2:0]      mps_code,
  input  logic            td_en,
  input  logic [31:0]     in_data,
  input  logic            in_valid,
  output logic            in_ready,
  output logic [31:0]     out_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_sop,
  output logic            out_eop,
  output logic            done
);
  localparam int RW = BC_W - 2;
  localparam logic [1:0] S_IDLE = 2'd0, S_HDR = 2'd1, S_DAT = 2'd2;

  logic [1:0]    st;
  logic [63:0]   addr_q;
  logic [RW-1:0] rem_q;
  logic [2:0]    code_q;
  logic          td_q;
  logic [10:0]   idx_q;

  wire [10:0] mps_dw = (code_q > 3'd5) ? 11'd32 : (11'd32 << code_q);
  wire [10:0] off_dw = {1'b0, addr_q[11:2]} & (mps_dw - 11'd1);
  wire [10:0] room   = mps_dw - off_dw;
  wire [10:0] seg    = (32'(rem_q) < 32'(room)) ? 11'(rem_q) : room;
  wire        is4    = |addr_q[63:32];
  wire [10:0] hdr_last = is4 ? 11'd3 : 11'd2;
  wire        beat   = out_valid && out_ready;
  wire        seg_end = (idx_q == seg - 11'd1);

  logic [31:0] hdr_word;
  always_comb begin
    case (idx_q[1:0])
      2'd0: hdr_word = {is4 ? 3'b011 : 3'b010, 5'b0, 8'h00, td_q, 5'b0, seg[9:0]};
      2'd1: hdr_word = {24'h0, (seg == 11'd1) ? 4'h0 : 4'hF, 4'hF};
      2'd2: hdr_word = is4 ? addr_q[63:32] : {addr_q[31:2], 2'b00};
      default: hdr_word = {addr_q[31:2], 2'b00};
    endcase
  end

  assign job_ready = (st == S_IDLE);
  assign out_valid = (st == S_HDR) || ((st == S_DAT) && in_valid);
  assign in_ready  = (st == S_DAT) && out_ready;
  assign out_data  = (st == S_DAT) ? in_data : hdr_word;
  assign out_sop   = (st == S_HDR) && (idx_q == 11'd0);
  assign out_eop   = (st == S_DAT) && seg_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      code_q <= '0;
      td_q   <= 1'b0;
      idx_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (job_valid && (job_bytes[BC_W-1:2] != '0)) begin
          addr_q <= {job_addr[63:2], 2'b00};
          rem_q  <= job_bytes[BC_W-1:2];
          code_q <= mps_code;
          td_q   <= td_en;
          idx_q  <= '0;
          st     <= S_HDR;
        end
        S_HDR: if (beat) begin
          if (idx_q == hdr_last) begin
            idx_q <= '0;
            st    <= S_DAT;
          end else idx_q <= idx_q + 11'd1;
        end
        S_DAT: if (beat) begin
          if (seg_end) begin
            addr_q <= addr_q + 64'({seg, 2'b00});
            rem_q  <= rem_q - RW'(seg);
            idx_q  <= '0;
            if (32'(rem_q) == 32'(seg)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else st <= S_HDR;
          end else idx_q <= idx_q + 11'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wr_tlp_segmenter_chk.sv
module wr_tlp_segmenter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        job_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_sop,
  input logic        out_eop,
  input logic [31:0] out_data,
  input logic        done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> !out_valid); // R8
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && !out_ready) |=> (out_valid && out_sop && $stable(out_data))); // R9
  AST_FMT_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> ((out_data[31:29] == 3'b010 || out_data[31:29] == 3'b011) && out_data[28:24] == 5'd0)); // R4
  AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_eop)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> job_ready); // R8
endmodule

bind wr_tlp_segmenter wr_tlp_segmenter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .job_ready(job_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
  .out_data(out_data), .done(done)
);

// File: tb/wr_tlp_segmenter_tb.sv
module wr_tlp_segmenter_tb;
  localparam int BC_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic job_valid = 1'b0, td_en = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [63:0] job_addr = '0;
  logic [BC_W-1:0] job_bytes = '0;
  logic [2:0] mps_code = '0;
  logic [31:0] in_data = '0;
  logic job_ready, in_ready, out_valid, out_sop, out_eop, done;
  logic [31:0] out_data;
  int checks = 0, fails = 0, cyc = 0, dcnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wr_tlp_segmenter #(.BC_W(BC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_bytes(job_bytes), .mps_code(mps_code), .td_en(td_en),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run_job(input logic [63:0] a, input int bytes, input logic [2:0] code,
                         input logic td, input bit busy);
    logic [63:0] e_addr = a;
    int e_rem = bytes / 4;
    int mps, room, seg, idx, hn;
    bit hdr, is4;
    @(negedge clk);
    job_addr = a; job_bytes = BC_W'(bytes); mps_code = code; td_en = td; job_valid = 1'b1;
    @(negedge clk);
    if (busy) begin
      job_addr = 64'h0000_0000_0000_1234; job_bytes = 16'd8; mps_code = 3'd7; td_en = ~td;
    end else job_valid = 1'b0;
    hdr = 1; idx = 0;
    while (e_rem > 0) begin
      mps = (code > 3'd5) ? 32 : (32 << code);
      room = mps - int'((e_addr >> 2) % 64'(mps));
      seg = (e_rem < room) ? e_rem : room;
      is4 = (e_addr[63:32] != 0);
      hn = is4 ? 4 : 3;
      out_ready = (cyc % 5) != 3;
      in_valid = (cyc % 7) != 2;
      in_data = 32'hA500_0000 + dcnt;
      cyc++;
      #1;
      if (out_valid && out_ready) begin
        if (hdr) begin
          case (idx)
            0: begin
              chk("R4/R3/R6 hdr dw0", out_data,
                  {is4 ? 3'b011 : 3'b010, 5'b0, 8'h00, td, 5'b0, 10'(seg)});
              chk("R8 sop", {31'd0, out_sop}, 32'd1);
            end
            1: chk("R7 hdr dw1", out_data, {24'h0, (seg == 1) ? 4'h0 : 4'hF, 4'hF});
            2: chk("R5 hdr dw2", out_data, is4 ? e_addr[63:32] : {e_addr[31:2], 2'b00});
            default: chk("R5 hdr dw3", out_data, {e_addr[31:2], 2'b00});
          endcase
          idx++;
          if (idx == hn) begin hdr = 0; idx = 0; end
        end else begin
          chk("R2 payload", out_data, 32'hA500_0000 + dcnt);
          chk("R8 eop", {31'd0, out_eop}, {31'd0, idx == seg - 1});
          dcnt++;
          idx++;
          if (idx == seg) begin
            e_addr = e_addr + 64'(seg * 4);
            e_rem = e_rem - seg;
            hdr = 1; idx = 0;
            if (e_rem == 0) job_valid = 1'b0;
          end
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0; in_valid = 1'b0;
    #1;
    chk("R8 done pulse", {31'd0, done}, 32'd1);
    chk("R8 idle after job", {31'd0, job_ready}, 32'd1);
  endtask

  initial begin
    logic [63:0] addrs [5];
    int lens [4];
    addrs[0] = 64'h0; addrs[1] = 64'h7C; addrs[2] = 64'hFFC;
    addrs[3] = 64'h1_0000_0F80; addrs[4] = 64'hFFFF_FF00;
    lens[0] = 4; lens[1] = 8; lens[2] = 260; lens[3] = 4100;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset job_ready", {31'd0, job_ready}, 32'd1);
    chk("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R8 reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 5; a++)
        for (int l = 0; l < 4; l++)
          run_job(addrs[a], lens[l], 3'(c), c[0], (c == 2) && (l == 3)); // R1 R9
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule